// File: doc/BRIEF.md
# Flash write status reporter

This block sits on the read path of a flash device and reports progress while an internal program or erase runs. The start strobe `op_start` marks the closing write pulse of a command sequence: the fourth pulse for a program, the sixth for an erase. From the next cycle until the done strobe `op_done`, a read that targets the location being written does not return plain array data. The top bit carries a polling flag and the bit below it flips on each read. Every other bit passes straight through from the array.

While an operation is in progress the block also asks an external open-drain ready/busy line to be pulled low. It does this through an enable that is high only when the line should be driven low. It never drives the line high. After a program finishes, the polling flag shows true data for a configurable number of clock cycles before plain reads resume. During that window the flipping bit stays frozen.

There is no data stream here with flow control. Reads are single-cycle strobes, and the read data path is combinational from registered state, so it never applies back-pressure. All control and status pins are plain levels or pulses.

Top module: `wstat_reporter`

## Requirements
- R1: After reset the block is idle: `rd_data` equals `array_data`, `rb_drive_low` is 0, and the flip bit (bit `DW-2`) state is 0.
- R2: While a program is in progress and `rd_hit` is 1, bit `DW-1` of `rd_data` is the complement of bit `DW-1` of the `op_data` captured with `op_start`.
- R3: While an erase is in progress and `rd_hit` is 1, bit `DW-1` of `rd_data` is 0. Once the erase ends it is the array bit again.
- R4: While an operation is in progress and `rd_hit` is 1, bit `DW-2` of `rd_data` shows a flip state. That state is 0 after reset and inverts after every qualified read (`rd_stb`=1, `ce_n`=0, `oe_n`=0) taken during the operation. The read itself returns the value from before the flip.
- R5: `rb_drive_low` is 1 from the cycle after an accepted `op_start` up to and including the cycle in which `op_done` is 1, provided `ce_n` and `oe_n` are 0.
- R6: `rb_drive_low` is 0 whenever `ce_n` is 1, `oe_n` is 1 or `rst_n` is 0.
- R7: For `HOLD_CYC` cycles after a program's `op_done`, a read with `rd_hit` returns the true captured bit on `DW-1` and the frozen flip state on `DW-2`. Plain reads follow after that.
- R8: `op_start` is ignored while an operation or post-program window is active, and `op_done` is ignored when no operation is in progress.
- R9: When `rd_hit` is 0, or no operation or window is active, `rd_data` equals `array_data` in every bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Device reset, active low, asynchronous |
| op_start | input | 1 | Pulse: final write pulse of a program or erase sequence |
| op_erase | input | 1 | Operation type with `op_start`: 1 erase, 0 program |
| op_data | input | DW | Byte being programmed, captured with `op_start` |
| op_done | input | 1 | Pulse: internal operation finished |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_stb | input | 1 | One-cycle pulse per read access |
| rd_hit | input | 1 | The current read targets the location being written |
| array_data | input | DW | Data read from the array |
| rd_data | output | DW | Read data with status bits substituted |
| rb_drive_low | output | 1 | Enable for pulling the open-drain ready/busy line low |

## Verification
The bench builds the block with `DW`=8 and `HOLD_CYC`=6. The short window lets a program's hold period expire many times within a few thousand cycles. It also lets new start strobes arrive both inside and just after that window. A random phase mixes reads, misses, deselects and stray strobes, so the flip state is checked across long runs of back-to-back operations and not only after reset.

// File: rtl/wstat_pkg.sv
package wstat_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PGM  = 2'd1,
    PH_ERS  = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;
endpackage

// File: rtl/wstat_phase.sv
module wstat_phase
  import wstat_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HOLD_CYC = 250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_start,
  input  logic          op_erase,
  input  logic [DW-1:0] op_data,
  input  logic          op_done,
  output phase_e        phase,
  output logic          cap_msb
);
  localparam int CW = $clog2(HOLD_CYC + 2);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC > 0 ? HOLD_CYC - 1 : 0);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      hold_cnt <= '0;
      cap_msb  <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (op_start) begin
          cap_msb <= op_data[DW-1];
          phase   <= op_erase ? PH_ERS : PH_PGM;
        end
        PH_PGM: if (op_done) begin
          if (HOLD_CYC == 0) phase <= PH_IDLE;
          else begin
            phase    <= PH_HOLD;
            hold_cnt <= HOLD_LAST;
          end
        end
        PH_ERS: if (op_done) phase <= PH_IDLE;
        PH_HOLD: begin
          if (hold_cnt == '0) phase <= PH_IDLE;
          else hold_cnt <= hold_cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wstat_toggle.sv
module wstat_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic rd_q,
  output logic tgl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            tgl_q <= 1'b0;
    else if (busy && rd_q) tgl_q <= ~tgl_q;
  end
endmodule

// File: rtl/wstat_outmux.sv
module wstat_outmux #(
  parameter int DW = 8
) (
  input  logic          rst_n,
  input  logic          busy,
  input  logic          erasing,
  input  logic          holding,
  input  logic          cap_msb,
  input  logic          tgl_q,
  input  logic          rd_hit,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          rb_drive_low
);
  localparam int POLL_BIT = DW - 1;
  localparam int FLIP_BIT = DW - 2;

  always_comb begin
    rd_data = array_data;
    if (rd_hit && (busy || holding)) begin
      if (erasing)      rd_data[POLL_BIT] = 1'b0;
      else if (holding) rd_data[POLL_BIT] = cap_msb;
      else              rd_data[POLL_BIT] = ~cap_msb;
      rd_data[FLIP_BIT] = tgl_q;
    end
  end

  assign rb_drive_low = busy && rst_n && !ce_n && !oe_n;
endmodule

// File: rtl/wstat_reporter.sv
module wstat_reporter
  import wstat_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HOLD_CYC = 250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_start,
  input  logic          op_erase,
  input  logic [DW-1:0] op_data,
  input  logic          op_done,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          rd_stb,
  input  logic          rd_hit,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          rb_drive_low
);
  phase_e phase;
  logic   cap_msb;
  logic   tgl_q;
  logic   st_busy;
  logic   st_erase;
  logic   st_hold;
  logic   rd_q;

  assign st_busy  = (phase == PH_PGM) || (phase == PH_ERS);
  assign st_erase = (phase == PH_ERS);
  assign st_hold  = (phase == PH_HOLD);
  assign rd_q     = rd_stb && !ce_n && !oe_n;

  wstat_phase #(.DW(DW), .HOLD_CYC(HOLD_CYC)) u_phase (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
    .op_data(op_data), .op_done(op_done), .phase(phase), .cap_msb(cap_msb)
  );

  wstat_toggle u_tgl (
    .clk(clk), .rst_n(rst_n), .busy(st_busy), .rd_q(rd_q), .tgl_q(tgl_q)
  );

  wstat_outmux #(.DW(DW)) u_mux (
    .rst_n(rst_n), .busy(st_busy), .erasing(st_erase), .holding(st_hold),
    .cap_msb(cap_msb), .tgl_q(tgl_q), .rd_hit(rd_hit), .ce_n(ce_n),
    .oe_n(oe_n), .array_data(array_data), .rd_data(rd_data),
    .rb_drive_low(rb_drive_low)
  );
endmodule

// File: rtl/wstat_chk.sv
module wstat_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_start,
  input logic          op_done,
  input logic          ce_n,
  input logic          oe_n,
  input logic          rd_stb,
  input logic          rd_hit,
  input logic [DW-1:0] rd_data,
  input logic          rb_drive_low,
  input logic          st_busy,
  input logic          st_erase,
  input logic          st_hold,
  input logic          tgl_q
);
  logic qual_rd;
  assign qual_rd = rd_stb && !ce_n && !oe_n;

  always_comb begin
    if (!rst_n) begin
      assert_rb_release_in_reset_R6: assert (!rb_drive_low);
    end
  end

  assert_rb_only_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !st_busy |-> !rb_drive_low);

  assert_rb_release_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> !rb_drive_low);

  assert_flip_per_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busy && qual_rd) |=> (tgl_q != $past(tgl_q)));

  assert_flip_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_hold |=> $stable(tgl_q));

  assert_erase_poll_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busy && st_erase && rd_hit) |-> !rd_data[DW-1]);

  assert_start_ignored_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busy && op_start && !op_done) |=> st_busy);
endmodule

bind wstat_reporter wstat_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_done(op_done),
  .ce_n(ce_n), .oe_n(oe_n), .rd_stb(rd_stb), .rd_hit(rd_hit),
  .rd_data(rd_data), .rb_drive_low(rb_drive_low), .st_busy(st_busy),
  .st_erase(st_erase), .st_hold(st_hold), .tgl_q(tgl_q)
);

// File: tb/sim_wstat_reporter.sv
`timescale 1ns/1ps
module sim_wstat_reporter;
  localparam int DW   = 8;
  localparam int HOLD = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_start = 1'b0, op_erase = 1'b0, op_done = 1'b0;
  logic [DW-1:0] op_data = '0;
  logic          ce_n = 1'b1, oe_n = 1'b1, rd_stb = 1'b0, rd_hit = 1'b0;
  logic [DW-1:0] array_data = '0;
  logic [DW-1:0] rd_data;
  logic          rb_drive_low;

  int vectors = 0;
  int errors  = 0;

  always #2 clk = ~clk;

  wstat_reporter #(.DW(DW), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
    .op_data(op_data), .op_done(op_done), .ce_n(ce_n), .oe_n(oe_n),
    .rd_stb(rd_stb), .rd_hit(rd_hit), .array_data(array_data),
    .rd_data(rd_data), .rb_drive_low(rb_drive_low)
  );

  // Reference model: 0 idle, 1 program, 2 erase, 3 post-program window
  int   m_ph  = 0;
  int   m_cnt = 0;
  logic m_d7  = 1'b0;
  logic m_tgl = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_d7 = 1'b0; m_tgl = 1'b0;
    end else begin
      if ((m_ph == 1 || m_ph == 2) && rd_stb && !ce_n && !oe_n) m_tgl = ~m_tgl;
      if (m_ph == 0) begin
        if (op_start) begin m_d7 = op_data[DW-1]; m_ph = op_erase ? 2 : 1; end
      end else if (m_ph == 1) begin
        if (op_done) begin m_ph = 3; m_cnt = HOLD; end
      end else if (m_ph == 2) begin
        if (op_done) m_ph = 0;
      end else begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_ph = 0;
      end
    end
  end

  function automatic logic [DW-1:0] exp_rd();
    logic [DW-1:0] e = array_data;
    if (rd_hit && m_ph != 0) begin
      e[DW-1] = (m_ph == 2) ? 1'b0 : (m_ph == 3) ? m_d7 : ~m_d7;
      e[DW-2] = m_tgl;
    end
    return e;
  endfunction

  function automatic logic exp_rb();
    return rst_n && !ce_n && !oe_n && (m_ph == 1 || m_ph == 2);
  endfunction

  task automatic tick();
    logic [DW-1:0] e;
    logic [DW-1:0] d;
    string tag;
    @(negedge clk);
    e = exp_rd();
    vectors++;
    if (rd_data !== e) begin
      d = rd_data ^ e;
      if (d[DW-2]) tag = "R4";
      else if (d[DW-1]) tag = (m_ph == 2) ? "R3" : (m_ph == 3) ? "R7" : (m_ph == 1) ? "R2" : "R9";
      else tag = "R9";
      errors++;
      $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, e);
    end
    vectors++;
    if (rb_drive_low !== exp_rb()) begin
      errors++;
      $display("FAIL %s rb_drive_low actual=%b expected=%b",
               (ce_n || oe_n || !rst_n) ? "R6" : "R5", rb_drive_low, exp_rb());
    end
  endtask

  task automatic start_op(input logic ers, input logic [DW-1:0] dat);
    op_start = 1'b1; op_erase = ers; op_data = dat;
    tick();
    op_start = 1'b0;
  endtask

  task automatic finish_op();
    op_done = 1'b1;
    tick();
    op_done = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    array_data = 8'h3C; rd_hit = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset, plain data, line released
    vectors++;
    if (rd_data !== 8'h3C || rb_drive_low !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual=%h/%b expected=3c/0", rd_data, rb_drive_low);
    end

    // R2, R4, R5: program 0xA5, reads flip bit 6, poll bit inverted
    start_op(1'b0, 8'hA5);
    rd_stb = 1'b1;
    repeat (5) tick();
    // R8: a second start during the program is ignored
    start_op(1'b1, 8'h00);
    rd_stb = 1'b0; tick();
    rd_stb = 1'b1;
    finish_op();
    // R7: window holds true bit and frozen flip state
    repeat (HOLD + 2) tick();
    rd_stb = 1'b0;

    // R3, R9, R6: erase, with misses and deselects
    start_op(1'b1, 8'h5A);
    rd_stb = 1'b1; repeat (3) tick();
    rd_hit = 1'b0; repeat (2) tick();   // R9
    rd_hit = 1'b1; ce_n = 1'b1; repeat (2) tick();  // R6
    ce_n = 1'b0; oe_n = 1'b1; tick();
    oe_n = 1'b0; array_data = 8'hFF;
    finish_op();
    repeat (3) tick();

    // R8: stray done while idle, start at the last cycle of a window
    finish_op();
    start_op(1'b0, 8'h11);
    finish_op();
    repeat (HOLD - 1) tick();
    start_op(1'b0, 8'h80);
    start_op(1'b0, 8'h80);
    repeat (3) tick();

    // R6: reset pulled during an operation releases the line at once
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();

    // Random mix covering R2..R9
    for (int i = 0; i < 4000; i++) begin
      op_start   = ($urandom % 16) == 0;
      op_erase   = $urandom % 2;
      op_data    = DW'($urandom);
      op_done    = ($urandom % 12) == 0;
      rd_stb     = $urandom % 2;
      rd_hit     = ($urandom % 4) != 0;
      ce_n       = ($urandom % 8) == 0;
      oe_n       = ($urandom % 8) == 0;
      array_data = DW'($urandom);
      tick();
    end
    summary();
  end
endmodule